// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block sits next to a two-port shared memory and gives each port a doorbell toward the other one. It watches the control and address lines of both ports and keeps one active-low interrupt output per port. A port posts a message by writing the mailbox word that belongs to the other port. The receiving side sees its interrupt go low. It takes the message by reading its own mailbox word, and that read releases the interrupt. The block holds no data. The memory array alongside it stores the mailbox contents.

The addresses are ADDR_W bits wide (11 by default). The left port owns the second-highest word, 0x7FE by default. The right port owns the highest word, 0x7FF. Access lines are sampled on the rising clock edge, and each interrupt output is a register that changes on the edge that samples the triggering access. When a post and a take of the same flag happen on the same edge, the post wins, so no message is lost.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, both `lft_irq_n` and `rgt_irq_n` become 1 (inactive) after that edge.
- R2: A right-port write (`rgt_cs_n`=0, `rgt_rw`=0) to address 0x7FE drives `lft_irq_n` to 0 after that edge.
- R3: A left-port write (`lft_cs_n`=0, `lft_rw`=0) to address 0x7FF drives `rgt_irq_n` to 0 after that edge.
- R4: A left-port read of 0x7FE with `lft_cs_n`=0, `lft_rw`=1 and `lft_oe_n`=0 returns `lft_irq_n` to 1 after that edge, unless R2 applies on the same edge.
- R5: A right-port read of 0x7FF with `rgt_cs_n`=0, `rgt_rw`=1 and `rgt_oe_n`=0 returns `rgt_irq_n` to 1 after that edge, unless R3 applies on the same edge.
- R6: No flag changes in any of these cases: a mailbox read with chip enable high, with output enable high, or with `rw`=0; a write with chip enable high; or an access to any address other than the mailbox words.
- R7: When a set (R2/R3) and a clear (R4/R5) of the same flag happen on the same edge, the flag ends at 0.
- R8: A write by a port to its own mailbox address (left to 0x7FE, right to 0x7FF) does not change that port's interrupt output.
- R9: On an edge with no set and no clear for a flag, that flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all access lines sampled on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lft_cs_n | input | 1 | Left chip enable, active low |
| lft_rw | input | 1 | Left direction: 1 read, 0 write |
| lft_oe_n | input | 1 | Left output enable, active low |
| lft_addr | input | ADDR_W | Left word address |
| rgt_cs_n | input | 1 | Right chip enable, active low |
| rgt_rw | input | 1 | Right direction: 1 read, 0 write |
| rgt_oe_n | input | 1 | Right output enable, active low |
| rgt_addr | input | ADDR_W | Right word address |
| lft_irq_n | output | 1 | Left interrupt, active low |
| rgt_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bench aims at the gating of the clear. A design that ignored output enable, chip enable or the direction bit would release an interrupt on a partial read, and the test would find the flag high when it should still be low. It drives a post and a take on one edge, both while the flag is low and while it is high. A design that let the clear win would lose the message and show a 1. Self-mailbox writes and writes to a neighbouring address are also applied, since a decoder that mixed up the two mailbox words would raise the wrong port's flag. A reset taken while both flags are low must return both to 1.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Decoded strobes for one port's access on the current edge
    typedef struct packed {
        logic sel;   // chip enabled
        logic wr;    // enabled write
        logic rd;    // enabled read with output enable
    } port_ctl_t;

    localparam int NUM_PORTS = 2;
    localparam int LEFT_IDX  = 0;
    localparam int RIGHT_IDX = 1;

    function automatic port_ctl_t decode_ctl(input logic cs_n,
                                             input logic rw,
                                             input logic oe_n);
        port_ctl_t c;
        c.sel = ~cs_n;
        c.wr  = ~cs_n & ~rw;
        c.rd  = ~cs_n & rw & ~oe_n;
        return c;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter logic [ADDR_W-1:0] OWN_BOX  = '0,
    parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
    input  logic              cs_n,
    input  logic              rw,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              post_hit,
    output logic              take_hit
);

    port_ctl_t ctl;

    always_comb begin
        ctl      = decode_ctl(cs_n, rw, oe_n);
        post_hit = ctl.wr & (addr == PEER_BOX);
        take_hit = ctl.rd & (addr == OWN_BOX);
    end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic irq_n
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_n <= 1'b1;
        end else if (set_req) begin
            irq_n <= 1'b0;
        end else if (clr_req) begin
            irq_n <= 1'b1;
        end
    end

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lft_cs_n,
    input  logic              lft_rw,
    input  logic              lft_oe_n,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic              rgt_cs_n,
    input  logic              rgt_rw,
    input  logic              rgt_oe_n,
    input  logic [ADDR_W-1:0] rgt_addr,
    output logic              lft_irq_n,
    output logic              rgt_irq_n
);

    localparam logic [ADDR_W-1:0] TOP_WORD  = '1;
    localparam logic [ADDR_W-1:0] LEFT_BOX  = TOP_WORD - 1'b1;
    localparam logic [ADDR_W-1:0] RIGHT_BOX = TOP_WORD;

    logic [NUM_PORTS-1:0] cs_n_v, rw_v, oe_n_v;
    logic [ADDR_W-1:0]    addr_v [NUM_PORTS];
    logic [NUM_PORTS-1:0] post_v, take_v, irq_v;

    assign cs_n_v = {rgt_cs_n, lft_cs_n};
    assign rw_v   = {rgt_rw, lft_rw};
    assign oe_n_v = {rgt_oe_n, lft_oe_n};
    assign addr_v[LEFT_IDX]  = lft_addr;
    assign addr_v[RIGHT_IDX] = rgt_addr;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] OWN  = (p == LEFT_IDX) ? LEFT_BOX : RIGHT_BOX;
        localparam logic [ADDR_W-1:0] PEER = (p == LEFT_IDX) ? RIGHT_BOX : LEFT_BOX;
        localparam int OTHER = NUM_PORTS - 1 - p;

        mbx_port_decode #(
            .ADDR_W  (ADDR_W),
            .OWN_BOX (OWN),
            .PEER_BOX(PEER)
        ) u_dec (
            .cs_n    (cs_n_v[p]),
            .rw      (rw_v[p]),
            .oe_n    (oe_n_v[p]),
            .addr    (addr_v[p]),
            .post_hit(post_v[p]),
            .take_hit(take_v[p])
        );

        mbx_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_req(post_v[OTHER]),
            .clr_req(take_v[p]),
            .irq_n  (irq_v[p])
        );
    end

    assign lft_irq_n = irq_v[LEFT_IDX];
    assign rgt_irq_n = irq_v[RIGHT_IDX];

endmodule

// File: rtl/mbx_irq_checker.sv
module mbx_irq_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              lft_cs_n,
    input logic              lft_rw,
    input logic              lft_oe_n,
    input logic [ADDR_W-1:0] lft_addr,
    input logic              rgt_cs_n,
    input logic              rgt_rw,
    input logic              rgt_oe_n,
    input logic [ADDR_W-1:0] rgt_addr,
    input logic              lft_irq_n,
    input logic              rgt_irq_n
);

    localparam logic [ADDR_W-1:0] HI = '1;
    localparam logic [ADDR_W-1:0] LO = HI - 1'b1;

    logic l_set, r_set, l_clr, r_clr;
    assign l_set = !rgt_cs_n && !rgt_rw && (rgt_addr == LO);
    assign r_set = !lft_cs_n && !lft_rw && (lft_addr == HI);
    assign l_clr = !lft_cs_n && lft_rw && !lft_oe_n && (lft_addr == LO);
    assign r_clr = !rgt_cs_n && rgt_rw && !rgt_oe_n && (rgt_addr == HI);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (lft_irq_n && rgt_irq_n));

    assert_left_set_R2: assert property (@(posedge clk) disable iff (rst)
        l_set |=> !lft_irq_n);

    assert_right_set_R3: assert property (@(posedge clk) disable iff (rst)
        r_set |=> !rgt_irq_n);

    assert_left_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (l_clr && !l_set) |=> lft_irq_n);

    assert_right_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (r_clr && !r_set) |=> rgt_irq_n);

    // R7: posting wins over taking on the same edge
    assert_set_priority_R7: assert property (@(posedge clk) disable iff (rst)
        (l_set && l_clr) |=> !lft_irq_n);

    // R9 (also covers R6, R8): no set and no clear keeps the flag
    assert_left_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!l_set && !l_clr) |=> $stable(lft_irq_n));

    assert_right_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!r_set && !r_clr) |=> $stable(rgt_irq_n));

endmodule

bind mbx_irq_ctrl mbx_irq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lft_cs_n (lft_cs_n),
    .lft_rw   (lft_rw),
    .lft_oe_n (lft_oe_n),
    .lft_addr (lft_addr),
    .rgt_cs_n (rgt_cs_n),
    .rgt_rw   (rgt_rw),
    .rgt_oe_n (rgt_oe_n),
    .rgt_addr (rgt_addr),
    .lft_irq_n(lft_irq_n),
    .rgt_irq_n(rgt_irq_n)
);

// File: tb/sim_mbx_irq_ctrl.sv
module sim_mbx_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 11;
    localparam int WATCHDOG   = 5000;
    localparam int NVEC       = 19;

    // Port field {cs_n, rw, oe_n, addr}
    localparam logic [13:0] I  = {3'b111, 11'h000};
    localparam logic [13:0] W7FE = {3'b001, 11'h7FE};
    localparam logic [13:0] W7FF = {3'b001, 11'h7FF};
    localparam logic [13:0] R7FE = {3'b010, 11'h7FE};
    localparam logic [13:0] R7FF = {3'b010, 11'h7FF};

    // {left, right, exp_lft_irq_n, exp_rgt_irq_n, req}
    localparam logic [33:0] VECS [NVEC] = '{
        {I, W7FE, 2'b01, 4'd2},                   // R2 right posts to left
        {I, I, 2'b01, 4'd9},                      // R9 idle holds
        {{3'b011, 11'h7FE}, I, 2'b01, 4'd6},      // R6 read, oe inactive
        {{3'b110, 11'h7FE}, I, 2'b01, 4'd6},      // R6 read, cs inactive
        {{3'b010, 11'h7FD}, I, 2'b01, 4'd6},      // R6 read of other address
        {W7FE, I, 2'b01, 4'd8},                   // R8 left writes own box
        {R7FE, I, 2'b11, 4'd4},                   // R4 left takes
        {I, {3'b101, 11'h7FE}, 2'b11, 4'd6},      // R6 write, cs inactive
        {I, {3'b001, 11'h7FD}, 2'b11, 4'd6},      // R6 write to other address
        {W7FF, I, 2'b10, 4'd3},                   // R3 left posts to right
        {I, W7FF, 2'b10, 4'd8},                   // R8 right writes own box
        {I, R7FF, 2'b11, 4'd5},                   // R5 right takes
        {W7FF, R7FF, 2'b10, 4'd7},                // R7 set wins, flag was high
        {W7FF, R7FF, 2'b10, 4'd7},                // R7 set wins, flag was low
        {R7FE, W7FE, 2'b00, 4'd7},                // R7 left side
        {{3'b000, 11'h7FE}, I, 2'b00, 4'd6},      // R6 oe low but write
        {R7FE, I, 2'b10, 4'd4},                   // R4
        {I, R7FF, 2'b11, 4'd5},                   // R5
        {W7FF, W7FE, 2'b00, 4'd2}                 // R2 and R3 together
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lft_cs_n = 1'b1, lft_rw = 1'b1, lft_oe_n = 1'b1;
    logic rgt_cs_n = 1'b1, rgt_rw = 1'b1, rgt_oe_n = 1'b1;
    logic [ADDR_W-1:0] lft_addr = '0, rgt_addr = '0;
    logic lft_irq_n, rgt_irq_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_irq_ctrl #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst),
        .lft_cs_n(lft_cs_n), .lft_rw(lft_rw), .lft_oe_n(lft_oe_n), .lft_addr(lft_addr),
        .rgt_cs_n(rgt_cs_n), .rgt_rw(rgt_rw), .rgt_oe_n(rgt_oe_n), .rgt_addr(rgt_addr),
        .lft_irq_n(lft_irq_n), .rgt_irq_n(rgt_irq_n)
    );

    task automatic check(input string tag, input logic exp_l, input logic exp_r);
        checks++;
        if (lft_irq_n !== exp_l || rgt_irq_n !== exp_r) begin
            errors++;
            $display("FAIL %s: irq_n l/r actual %b/%b expected %b/%b",
                     tag, lft_irq_n, rgt_irq_n, exp_l, exp_r);
        end
    endtask

    task automatic drive(input logic [13:0] l, input logic [13:0] r);
        {lft_cs_n, lft_rw, lft_oe_n, lft_addr} = l;
        {rgt_cs_n, rgt_rw, rgt_oe_n, rgt_addr} = r;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R1 reset", 1'b1, 1'b1);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i][33:20], VECS[i][19:6]);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[i][3:0], i), VECS[i][5], VECS[i][4]);
        end

        // R9: flags hold over several idle cycles
        drive(I, I);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
        check("R9 idle hold", 1'b0, 1'b0);

        // R1: reset while both flags are low, even with a post pending
        rst = 1'b1;
        drive(W7FF, W7FE);
        @(posedge clk);
        @(negedge clk);
        check("R1 mid-run reset", 1'b1, 1'b1);
        rst = 1'b0;
        drive(I, I);
        @(posedge clk);
        @(negedge clk);
        check("R1 after reset release", 1'b1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule